// File: doc/BRIEF.md
# Receive PHY Bring-up and Rate Configuration Sequencer

This block powers up a multi-lane receive PHY and sets its high-speed frequency range. A start command supplies the link rate in Mbps and the number of active lanes. The block then works through a fixed sequence. It loads the lane register and holds the PHY in shutdown and reset. It pulses the test clear line, with minimum microsecond gaps around the pulse.

Next it turns the rate into a 6-bit range code by searching a threshold table, one entry per clock. It hands that code, shifted left one bit, to an external test transaction engine under a fixed test code. A request/done handshake reaches the engine. Last, it releases shutdown, then the PHY reset, then the controller reset, with settle waits between those steps.

A stop command, accepted while the block is idle, returns the lane register to a single lane and drops the controller reset. Every wait is counted in microseconds. A prescaler that divides the system clock by `CLK_MHZ` produces each microsecond.

Top module: `phy_bringup_seq`

## Requirements
- R1: A start accepted while idle loads `lane_cfg_o` with `lanes_i - 1` on the next clock edge. A stop accepted while idle loads it with 0.
- R2: On that same edge after a start, `phy_rstz_o` and `phy_shutdownz_o` go low. One clock later, `test_clk_o` goes high, `test_en_o` goes low and `test_clr_o` goes high.
- R3: `test_clr_o` stays high for exactly `US_CLR * CLK_MHZ` cycles. A second gap of the same length follows before the rate search begins.
- R4: The range code belongs to the first table entry whose threshold is at least the latched rate. Thresholds climb from 89 to 1500. Examples: 89 gives 6'h00, 90 gives 6'h10, 1000 gives 6'h2A, and 1500 gives 6'h3C. A rate above 1500 uses the last entry, 6'h3C. The search finishes k+2 cycles after it begins, where k is the index of the matching entry.
- R5: `range_err_o` is set by a start whose rate is below 80 or above 1500, and cleared by a start with any other rate. The sequence runs to the end in both cases.
- R6: `txn_req_o` rises when the search ends. While it is high, `txn_code_o` is 8'h44 and `txn_data_o` is `{1'b0, code, 1'b0}`. It falls on the edge where `txn_done_i` is sampled high.
- R7: After the handshake, a wait of `US_PROG` µs ends with `phy_shutdownz_o` going high. A second `US_PROG` µs wait ends with `phy_rstz_o` going high. One cycle later `ctrl_resetn_o` becomes all ones. After `US_SETTLE` µs more, `done_o` pulses for one cycle and `busy_o` falls.
- R8: Start and stop while busy are ignored. When start and stop arrive together while idle, the stop wins and no sequence begins.
- R9: Under synchronous reset, all outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin bring-up (taken only when idle) |
| stop_i | input | 1 | Stop command (taken only when idle) |
| rate_mbps_i | input | 11 | Link rate in Mbps, latched at start |
| lanes_i | input | LCNT_W | Active lane count, 1..MAX_LANES |
| lane_cfg_o | output | LANE_W | Lane register (count minus one) |
| phy_rstz_o | output | 1 | PHY reset, active low |
| phy_shutdownz_o | output | 1 | PHY shutdown, active low |
| test_clk_o | output | 1 | Test interface clock level |
| test_en_o | output | 1 | Test interface enable level |
| test_clr_o | output | 1 | Test interface clear |
| txn_req_o | output | 1 | Request to the test transaction engine |
| txn_code_o | output | 8 | Test code for the transaction |
| txn_data_o | output | 8 | Data byte for the transaction |
| txn_done_i | input | 1 | Engine completion pulse |
| ctrl_resetn_o | output | CRST_W | Controller reset word, all ones when released |
| range_err_o | output | 1 | Rate outside 80..1500 at last start |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle pulse at end of sequence |

## Verification
Start and stop can arrive in the same idle cycle. The bench raises both lines together and expects the stop's effect alone: the lane register and controller reset go to zero, and busy stays low. Start and stop pulses are also driven in the middle of a running sequence. There, the reference model demands that no pin timing shifts and no register changes. A per-clock comparison against that model judges both cases.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PREP, ST_CLR_HI, ST_CLR_LO, ST_SEARCH,
        ST_TXN, ST_HOLD, ST_SD_GAP, ST_RST_REL, ST_SETTLE
    } seq_state_t;

    typedef struct packed {
        logic [10:0] limit;
        logic [5:0]  code;
    } range_entry_t;

    localparam int unsigned RANGE_ENTRIES = 39;
    localparam int unsigned RATE_MIN      = 80;
    localparam int unsigned RATE_MAX      = 1500;

    function automatic range_entry_t range_entry(input logic [5:0] idx);
        range_entry_t e;
        case (idx)
            6'd0:  e = '{11'd89,   6'h00};
            6'd1:  e = '{11'd99,   6'h10};
            6'd2:  e = '{11'd109,  6'h20};
            6'd3:  e = '{11'd129,  6'h01};
            6'd4:  e = '{11'd139,  6'h11};
            6'd5:  e = '{11'd149,  6'h21};
            6'd6:  e = '{11'd169,  6'h02};
            6'd7:  e = '{11'd179,  6'h12};
            6'd8:  e = '{11'd199,  6'h22};
            6'd9:  e = '{11'd219,  6'h03};
            6'd10: e = '{11'd239,  6'h13};
            6'd11: e = '{11'd249,  6'h23};
            6'd12: e = '{11'd269,  6'h04};
            6'd13: e = '{11'd299,  6'h14};
            6'd14: e = '{11'd329,  6'h05};
            6'd15: e = '{11'd359,  6'h15};
            6'd16: e = '{11'd399,  6'h25};
            6'd17: e = '{11'd449,  6'h06};
            6'd18: e = '{11'd499,  6'h16};
            6'd19: e = '{11'd549,  6'h07};
            6'd20: e = '{11'd599,  6'h17};
            6'd21: e = '{11'd649,  6'h08};
            6'd22: e = '{11'd699,  6'h18};
            6'd23: e = '{11'd749,  6'h09};
            6'd24: e = '{11'd799,  6'h19};
            6'd25: e = '{11'd849,  6'h29};
            6'd26: e = '{11'd899,  6'h39};
            6'd27: e = '{11'd949,  6'h0A};
            6'd28: e = '{11'd999,  6'h1A};
            6'd29: e = '{11'd1049, 6'h2A};
            6'd30: e = '{11'd1099, 6'h3A};
            6'd31: e = '{11'd1149, 6'h0B};
            6'd32: e = '{11'd1199, 6'h1B};
            6'd33: e = '{11'd1249, 6'h2B};
            6'd34: e = '{11'd1299, 6'h3B};
            6'd35: e = '{11'd1349, 6'h0C};
            6'd36: e = '{11'd1399, 6'h1C};
            6'd37: e = '{11'd1449, 6'h2C};
            default: e = '{11'd1500, 6'h3C};
        endcase
        return e;
    endfunction

    function automatic logic rate_outside(input logic [10:0] rate);
        return (32'(rate) < RATE_MIN) || (32'(rate) > RATE_MAX);
    endfunction

endpackage

// File: rtl/us_prescaler.sv
module us_prescaler #(
    parameter int unsigned CLK_MHZ = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

    logic [PW-1:0] cnt_q;

    assign tick_o = (cnt_q == PW'(CLK_MHZ - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i || tick_o) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    // R3
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (CLK_MHZ > 1 && clr_i) |=> !tick_o);

endmodule

// File: rtl/range_search.sv
module range_search
    import phy_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go_i,
    input  logic [10:0] rate_i,
    output logic        done_o,
    output logic [5:0]  code_o
);
    logic [5:0]   idx_q;
    logic         active_q;
    range_entry_t ent;
    logic         hit;

    assign ent = range_entry(idx_q);
    assign hit = (rate_i <= ent.limit) || (idx_q == 6'(RANGE_ENTRIES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            active_q <= 1'b0;
            done_o   <= 1'b0;
            code_o   <= '0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                idx_q    <= '0;
                active_q <= 1'b1;
            end else if (active_q) begin
                if (hit) begin
                    active_q <= 1'b0;
                    done_o   <= 1'b1;
                    code_o   <= ent.code;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // R4
    search_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(active_q) && !active_q));

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 10,
    parameter int unsigned MAX_LANES = 4,
    parameter int unsigned CRST_W    = 32,
    parameter int unsigned US_CLR    = 15,
    parameter int unsigned US_PROG   = 5,
    parameter int unsigned US_SETTLE = 10,
    parameter logic [7:0]  TEST_CODE = 8'h44,
    localparam int unsigned LANE_W   = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
    localparam int unsigned LCNT_W   = $clog2(MAX_LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [10:0]       rate_mbps_i,
    input  logic [LCNT_W-1:0] lanes_i,
    output logic [LANE_W-1:0] lane_cfg_o,
    output logic              phy_rstz_o,
    output logic              phy_shutdownz_o,
    output logic              test_clk_o,
    output logic              test_en_o,
    output logic              test_clr_o,
    output logic              txn_req_o,
    output logic [7:0]        txn_code_o,
    output logic [7:0]        txn_data_o,
    input  logic              txn_done_i,
    output logic [CRST_W-1:0] ctrl_resetn_o,
    output logic              range_err_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int unsigned US_W = $clog2(US_CLR + US_PROG + US_SETTLE + 1);

    seq_state_t  st_q, st_d;
    logic        tick, adv, wait_end, srch_go, srch_done;
    logic [5:0]  srch_code;
    logic [10:0] rate_q;
    logic [US_W-1:0] us_q, us_len;

    us_prescaler #(.CLK_MHZ(CLK_MHZ)) u_pre (
        .clk(clk), .rst(rst), .clr_i(adv), .tick_o(tick)
    );

    range_search u_srch (
        .clk(clk), .rst(rst), .go_i(srch_go), .rate_i(rate_q),
        .done_o(srch_done), .code_o(srch_code)
    );

    always_comb begin
        case (st_q)
            ST_CLR_HI, ST_CLR_LO: us_len = US_W'(US_CLR);
            ST_HOLD, ST_SD_GAP:   us_len = US_W'(US_PROG);
            default:              us_len = US_W'(US_SETTLE);
        endcase
    end

    assign wait_end = tick && (us_q == us_len - 1'b1);

    always_comb begin
        st_d    = st_q;
        srch_go = 1'b0;
        case (st_q)
            ST_IDLE:    if (start_i && !stop_i) st_d = ST_PREP;
            ST_PREP:    st_d = ST_CLR_HI;
            ST_CLR_HI:  if (wait_end) st_d = ST_CLR_LO;
            ST_CLR_LO:  if (wait_end) begin st_d = ST_SEARCH; srch_go = 1'b1; end
            ST_SEARCH:  if (srch_done) st_d = ST_TXN;
            ST_TXN:     if (txn_done_i) st_d = ST_HOLD;
            ST_HOLD:    if (wait_end) st_d = ST_SD_GAP;
            ST_SD_GAP:  if (wait_end) st_d = ST_RST_REL;
            ST_RST_REL: st_d = ST_SETTLE;
            ST_SETTLE:  if (wait_end) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    assign adv        = (st_d != st_q);
    assign busy_o     = (st_q != ST_IDLE);
    assign txn_code_o = TEST_CODE;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q            <= ST_IDLE;
            us_q            <= '0;
            rate_q          <= '0;
            lane_cfg_o      <= '0;
            phy_rstz_o      <= 1'b0;
            phy_shutdownz_o <= 1'b0;
            test_clk_o      <= 1'b0;
            test_en_o       <= 1'b0;
            test_clr_o      <= 1'b0;
            txn_req_o       <= 1'b0;
            txn_data_o      <= '0;
            ctrl_resetn_o   <= '0;
            range_err_o     <= 1'b0;
            done_o          <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_o <= 1'b0;
            if (adv)       us_q <= '0;
            else if (tick) us_q <= us_q + 1'b1;
            case (st_q)
                ST_IDLE: begin
                    if (stop_i) begin
                        lane_cfg_o    <= '0;
                        ctrl_resetn_o <= '0;
                    end else if (start_i) begin
                        lane_cfg_o      <= LANE_W'(lanes_i - 1'b1);
                        phy_rstz_o      <= 1'b0;
                        phy_shutdownz_o <= 1'b0;
                        rate_q          <= rate_mbps_i;
                        range_err_o     <= rate_outside(rate_mbps_i);
                    end
                end
                ST_PREP: begin
                    test_clk_o <= 1'b1;
                    test_en_o  <= 1'b0;
                    test_clr_o <= 1'b1;
                end
                ST_CLR_HI:  if (wait_end) test_clr_o <= 1'b0;
                ST_SEARCH: if (srch_done) begin
                    txn_req_o  <= 1'b1;
                    txn_data_o <= {1'b0, srch_code, 1'b0};
                end
                ST_TXN:     if (txn_done_i) txn_req_o <= 1'b0;
                ST_HOLD:    if (wait_end) phy_shutdownz_o <= 1'b1;
                ST_SD_GAP:  if (wait_end) phy_rstz_o <= 1'b1;
                ST_RST_REL: ctrl_resetn_o <= '1;
                ST_SETTLE:  if (wait_end) done_o <= 1'b1;
                default: ;
            endcase
        end
    end

    // R6
    txn_in_shutdown_chk: assert property (@(posedge clk) disable iff (rst)
        txn_req_o |-> (!phy_shutdownz_o && !phy_rstz_o && !test_clr_o));

    // R7
    release_order_chk: assert property (@(posedge clk) disable iff (rst)
        phy_rstz_o |-> phy_shutdownz_o);

    // R3
    clear_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        test_clr_o |-> (!phy_rstz_o && !phy_shutdownz_o && busy_o));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    busy_ignores_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(lane_cfg_o));

endmodule

// File: tb/phy_bringup_seq_bench.sv
module phy_bringup_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int M = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic start_i = 0, stop_i = 0, txn_done_i = 0;
    logic [10:0] rate_mbps_i = '0;
    logic [2:0]  lanes_i = '0;
    logic [1:0]  lane_cfg_o;
    logic phy_rstz_o, phy_shutdownz_o, test_clk_o, test_en_o, test_clr_o;
    logic txn_req_o, range_err_o, busy_o, done_o;
    logic [7:0]  txn_code_o, txn_data_o;
    logic [31:0] ctrl_resetn_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_bringup_seq u_phy_bringup_seq (.*);

    int vecs = 0, errs = 0;
    bit finished = 0, compare_on = 0;

    int lim [39] = '{89,99,109,129,139,149,169,179,199,219,239,249,269,299,329,
                     359,399,449,499,549,599,649,699,749,799,849,899,949,999,1049,
                     1099,1149,1199,1249,1299,1349,1399,1449,1500};
    int cod [39] = '{'h00,'h10,'h20,'h01,'h11,'h21,'h02,'h12,'h22,'h03,'h13,'h23,
                     'h04,'h14,'h05,'h15,'h25,'h06,'h16,'h07,'h17,'h08,'h18,'h09,
                     'h19,'h29,'h39,'h0A,'h1A,'h2A,'h3A,'h0B,'h1B,'h2B,'h3B,'h0C,
                     'h1C,'h2C,'h3C};

    function automatic int find_idx(int r);
        for (int i = 0; i < 39; i++) if (r <= lim[i]) return i;
        return 38;
    endfunction

    // reference model state
    int  e_lane, e_data, k;
    bit  e_rstz, e_shut, e_tclk, e_ten, e_tclr, e_req, e_err, e_busy, e_done, e_ctrl;

    task automatic model_reset();
        e_lane = 0; e_rstz = 0; e_shut = 0; e_tclk = 0; e_ten = 0; e_tclr = 0;
        e_req = 0; e_data = 0; e_err = 0; e_busy = 0; e_done = 0; e_ctrl = 0;
    endtask

    initial begin
        model_reset();
        forever begin
            @(posedge clk);
            e_done = 0;
            if (rst) begin model_reset(); continue; end
            if (stop_i) begin e_lane = 0; e_ctrl = 0; end
            else if (start_i) begin
                e_lane = (int'(lanes_i) - 1) & 3; e_rstz = 0; e_shut = 0;
                e_err = (rate_mbps_i < 80) || (rate_mbps_i > 1500); e_busy = 1;
                k = find_idx(int'(rate_mbps_i));
                @(posedge clk); e_tclk = 1; e_ten = 0; e_tclr = 1;
                repeat (15*M) @(posedge clk); e_tclr = 0;
                repeat (15*M) @(posedge clk);
                repeat (k + 2) @(posedge clk); e_req = 1; e_data = cod[k] << 1;
                @(posedge clk);
                while (txn_done_i !== 1'b1) @(posedge clk);
                e_req = 0;
                repeat (5*M) @(posedge clk); e_shut = 1;
                repeat (5*M) @(posedge clk); e_rstz = 1;
                @(posedge clk); e_ctrl = 1;
                repeat (10*M) @(posedge clk); e_done = 1; e_busy = 0;
            end
        end
    end

    task automatic cmp(string req, string nm, int act, int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (compare_on && !finished) begin
        cmp("R1", "lane_cfg", int'(lane_cfg_o), e_lane);
        cmp("R2/R7", "phy_rstz", int'(phy_rstz_o), int'(e_rstz));
        cmp("R2/R7", "phy_shutdownz", int'(phy_shutdownz_o), int'(e_shut));
        cmp("R2", "test_clk", int'(test_clk_o), int'(e_tclk));
        cmp("R2", "test_en", int'(test_en_o), int'(e_ten));
        cmp("R3", "test_clr", int'(test_clr_o), int'(e_tclr));
        cmp("R6", "txn_req", int'(txn_req_o), int'(e_req));
        if (e_req) begin
            cmp("R6", "txn_code", int'(txn_code_o), 'h44);
            cmp("R4", "txn_data", int'(txn_data_o), e_data);
        end
        cmp("R5", "range_err", int'(range_err_o), int'(e_err));
        cmp("R7/R8", "ctrl_resetn", int'(ctrl_resetn_o == '1), int'(e_ctrl));
        cmp("R8", "ctrl_resetn_zero", int'(ctrl_resetn_o == '0), int'(!e_ctrl));
        cmp("R7", "busy", int'(busy_o), int'(e_busy));
        cmp("R7", "done", int'(done_o), int'(e_done));
    end

    // test transaction engine: answers a request after three cycles
    initial forever begin
        @(negedge clk);
        if (txn_req_o === 1'b1) begin
            repeat (3) @(negedge clk);
            txn_done_i = 1;
            @(negedge clk);
            txn_done_i = 0;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    task automatic run(int rate, int lanes, bit poke);
        @(negedge clk);
        start_i = 1; rate_mbps_i = 11'(rate); lanes_i = 3'(lanes);
        @(negedge clk);
        start_i = 0;
        if (poke) begin   // R8: commands while busy are ignored
            repeat (40) @(negedge clk);
            start_i = 1; stop_i = 1; rate_mbps_i = 11'd50; lanes_i = 3'd1;
            @(negedge clk);
            start_i = 0; stop_i = 0;
        end
        while (done_o !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_on = 1;    // R9: reset values checked on this first compare
        rst = 0;
        run(1000, 4, 1);   // R4 mid-table
        run(50, 2, 0);     // R5 below range, first entry
        run(89, 1, 0);     // R4 boundary equal to first threshold
        run(90, 3, 0);     // R4 just above first threshold
        run(1500, 4, 0);   // R4 last entry, no error
        run(1600, 2, 1);   // R5 above range, last entry
        run(80, 1, 0);     // R5 lower edge accepted
        @(negedge clk); stop_i = 1;            // R8 stop while idle
        @(negedge clk); stop_i = 0;
        repeat (2) @(negedge clk);
        run(300, 3, 0);
        @(negedge clk); stop_i = 1; start_i = 1;   // R8 stop wins over start
        @(negedge clk); stop_i = 0; start_i = 0;
        repeat (20) @(negedge clk);
        @(negedge clk); rst = 1;                 // R9 reset mid-idle
        repeat (2) @(negedge clk); rst = 0;
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule